// File: doc/BRIEF.md
# Wide-Key Ternary Match Table

This block is a small ternary match table whose wide logical entries are each built from four consecutive narrow storage words. A 272-bit search key reaches the block as four 68-bit command beats. Once the fourth beat arrives, the assembled key is compared against every wide entry at once. The compare applies two masks. The first is a global mask assembled from a bank of mask registers. The second is a per-bit local mask stored beside each narrow data word.

The global mask has two halves, and each half is picked by an index. The index carried with the first beat selects the half that covers the upper 136 key bits. The index carried with the third beat selects the half that covers the lower 136 key bits. Among all matching wide entries, the lowest-numbered one wins. The block reports that winner as a narrow location address, together with a hit flag.

A simple load port writes data and local-mask words into narrow locations. A second load port writes the global-mask bank. One search can be issued every four clock cycles.

Top module: `wkt_search`

## Requirements
- R1: The key is assembled with the first beat (the one flagged by `cmd_first`) as key bits 271:204, then the second, third and fourth beats in descending order down to bits 67:0. Wide entry w compares key bits 271:204 against narrow location 4w and key bits 67:0 against narrow location 4w+3.
- R2: A key bit is ignored in the compare when its global mask bit is 0 or when its stored local mask bit is 1. Every other bit must equal the stored data bit.
- R3: The global mask for key bits 271:136 is the bank word indexed by `cmd_gidx` on the first beat. The mask for key bits 135:0 is the bank word indexed on the third beat. Bank word bit j covers key bit 136+j in the upper half and key bit j in the lower half. `cmd_gidx` on the second and fourth beats has no effect.
- R4: When several wide entries match, the lowest-numbered one wins.
- R5: On a hit, `res_idx` equals 4 times the winning wide entry number, so its two least significant bits are 00.
- R6: When no entry matches, `res_hit` is 0 and `res_idx` is 0.
- R7: `res_vld` is a one-cycle pulse in the cycle after the fourth beat is accepted. Between pulses, `res_hit` and `res_idx` hold the last result.
- R8: A beat with `cmd_first` set always starts a new key and abandons any partial one. A beat without `cmd_first` is ignored while no key is in progress. Searches may follow back to back, one every four cycles.
- R9: A load issued in the same cycle as a fourth beat does not affect that search. It does affect the next search.
- R10: After reset, `res_vld`, `res_hit` and `res_idx` are 0. Every mask bank word is all ones, and all stored data and local mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_vld | input | 1 | A key beat is present |
| cmd_first | input | 1 | Marks the first beat of a key |
| cmd_data | input | 68 | Key beat data |
| cmd_gidx | input | 3 | Mask bank index; used on the first and third beats |
| ld_en | input | 1 | Write one narrow location |
| ld_addr | input | 6 | Narrow location address |
| ld_data | input | 68 | Data word to store |
| ld_lmask | input | 68 | Local mask word to store (1 = don't care) |
| gm_ld_en | input | 1 | Write one mask bank word |
| gm_ld_idx | input | 3 | Mask bank word index |
| gm_ld_val | input | 136 | Mask bank word value (0 = don't care) |
| res_vld | output | 1 | Search result pulse |
| res_hit | output | 1 | Some wide entry matched |
| res_idx | output | 6 | Narrow address of the winning entry |

## Verification
Two functions can fall in the same cycle: a table load and the fourth key beat, which triggers the compare. The bench provokes this by writing a different word into the first location of the entry being searched in exactly the cycle the fourth beat is driven. It then judges the result by requiring a hit on that entry, which means the old contents were used. It follows with a second search for the same key and requires a miss, which shows the write did land. The same overlap of a new key with an old result is covered by driving two searches with no idle cycle between them.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

   // Variant of the lowest-index priority resolver.
   typedef enum int {
      PRIO_SCAN    = 0,   // descending scan, last assignment wins
      PRIO_ISOLATE = 1    // isolate lowest set bit, then OR-encode
   } prio_style_e;

   // Top bit of beat b in a key of nb beats, each bw bits wide.
   function automatic int beat_msb(input int b, input int nb, input int bw);
      return (nb - b) * bw - 1;
   endfunction

endpackage

// File: rtl/wkt_key_asm.sv
module wkt_key_asm #(
   parameter int BEAT_W  = 68,
   parameter int N_BEATS = 4,
   parameter int GIW     = 3,
   localparam int KEY_W  = BEAT_W * N_BEATS,
   localparam int CNT_W  = $clog2(N_BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              beat_vld,
   input  logic              beat_first,
   input  logic [BEAT_W-1:0] beat_data,
   input  logic [GIW-1:0]    beat_gidx,
   output logic              fire,
   output logic [KEY_W-1:0]  key,
   output logic [GIW-1:0]    gidx_hi,
   output logic [GIW-1:0]    gidx_lo
);
   import wkt_pkg::*;

   localparam int MID_BEAT = N_BEATS / 2;

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BEAT_W-1:0] hold_q [N_BEATS-1];
   logic [GIW-1:0]    ghi_q, glo_q;
   logic              take_next;

   assign take_next = beat_vld & ~beat_first & busy_q;
   assign fire      = take_next & (cnt_q == CNT_W'(N_BEATS - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         ghi_q  <= '0;
         glo_q  <= '0;
      end else if (beat_vld && beat_first) begin
         hold_q[0] <= beat_data;
         ghi_q     <= beat_gidx;
         cnt_q     <= CNT_W'(1);
         busy_q    <= 1'b1;
      end else if (take_next) begin
         if (fire) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            hold_q[cnt_q] <= beat_data;
            if (cnt_q == CNT_W'(MID_BEAT)) glo_q <= beat_gidx;
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   for (genvar b = 0; b < N_BEATS - 1; b++) begin : g_held
      assign key[beat_msb(b, N_BEATS, BEAT_W) -: BEAT_W] = hold_q[b];
   end
   assign key[BEAT_W-1:0] = beat_data;

   assign gidx_hi = ghi_q;
   assign gidx_lo = glo_q;

endmodule

// File: rtl/wkt_gmask_bank.sv
module wkt_gmask_bank #(
   parameter int HALF_W = 136,
   parameter int N_GM   = 8,
   localparam int GIW   = $clog2(N_GM)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [GIW-1:0]      wr_idx,
   input  logic [HALF_W-1:0]   wr_val,
   input  logic [GIW-1:0]      sel_hi,
   input  logic [GIW-1:0]      sel_lo,
   output logic [2*HALF_W-1:0] gmask
);
   logic [HALF_W-1:0] bank_q [N_GM];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_GM; i++) bank_q[i] <= '1;
      end else if (wr_en) begin
         bank_q[wr_idx] <= wr_val;
      end
   end

   assign gmask = {bank_q[sel_hi], bank_q[sel_lo]};

endmodule

// File: rtl/wkt_match_array.sv
module wkt_match_array #(
   parameter int BEAT_W  = 68,
   parameter int N_BEATS = 4,
   parameter int N_WIDE  = 16,
   localparam int KEY_W  = BEAT_W * N_BEATS,
   localparam int NARROW = N_WIDE * N_BEATS,
   localparam int AW     = $clog2(NARROW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [BEAT_W-1:0] wr_data,
   input  logic [BEAT_W-1:0] wr_lmask,
   input  logic [KEY_W-1:0]  key,
   input  logic [KEY_W-1:0]  gmask,
   output logic [N_WIDE-1:0] hits
);
   import wkt_pkg::*;

   logic [BEAT_W-1:0] dat_q [NARROW];
   logic [BEAT_W-1:0] lmk_q [NARROW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NARROW; i++) begin
            dat_q[i] <= '0;
            lmk_q[i] <= '0;
         end
      end else if (wr_en) begin
         dat_q[wr_addr] <= wr_data;
         lmk_q[wr_addr] <= wr_lmask;
      end
   end

   for (genvar w = 0; w < N_WIDE; w++) begin : g_ent
      logic [KEY_W-1:0] wd, wl;
      for (genvar b = 0; b < N_BEATS; b++) begin : g_loc
         assign wd[beat_msb(b, N_BEATS, BEAT_W) -: BEAT_W] = dat_q[w*N_BEATS + b];
         assign wl[beat_msb(b, N_BEATS, BEAT_W) -: BEAT_W] = lmk_q[w*N_BEATS + b];
      end
      assign hits[w] = ~|((wd ^ key) & gmask & ~wl);
   end

endmodule

// File: rtl/wkt_prio_enc.sv
module wkt_prio_enc #(
   parameter int                   N     = 16,
   parameter wkt_pkg::prio_style_e STYLE = wkt_pkg::PRIO_SCAN,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   import wkt_pkg::*;

   assign any = |req;

   if (STYLE == PRIO_SCAN) begin : g_scan
      always_comb begin
         idx = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
         end
      end
   end else begin : g_iso
      logic [N-1:0] lowest;
      assign lowest = req & (~req + N'(1));
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) begin
            if (lowest[i]) idx = idx | IW'(i);
         end
      end
   end

endmodule

// File: rtl/wkt_search.sv
module wkt_search #(
   parameter int                   BEAT_W     = 68,
   parameter int                   N_BEATS    = 4,
   parameter int                   N_WIDE     = 16,
   parameter int                   N_GM       = 8,
   parameter wkt_pkg::prio_style_e PRIO_STYLE = wkt_pkg::PRIO_SCAN,
   localparam int KEY_W  = BEAT_W * N_BEATS,
   localparam int HALF_W = KEY_W / 2,
   localparam int NARROW = N_WIDE * N_BEATS,
   localparam int AW     = $clog2(NARROW),
   localparam int OFS_W  = $clog2(N_BEATS),
   localparam int WIW    = $clog2(N_WIDE),
   localparam int GIW    = $clog2(N_GM)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic              cmd_first,
   input  logic [BEAT_W-1:0] cmd_data,
   input  logic [GIW-1:0]    cmd_gidx,
   input  logic              ld_en,
   input  logic [AW-1:0]     ld_addr,
   input  logic [BEAT_W-1:0] ld_data,
   input  logic [BEAT_W-1:0] ld_lmask,
   input  logic              gm_ld_en,
   input  logic [GIW-1:0]    gm_ld_idx,
   input  logic [HALF_W-1:0] gm_ld_val,
   output logic              res_vld,
   output logic              res_hit,
   output logic [AW-1:0]     res_idx
);

   // Elaboration-time parameter checks
   if (N_BEATS < 4 || (N_BEATS % 2) != 0 || (1 << OFS_W) != N_BEATS) begin : g_bad_beats
      $error("N_BEATS must be an even power of two of at least 4");
   end
   if (N_WIDE < 2 || (1 << WIW) != N_WIDE) begin : g_bad_wide
      $error("N_WIDE must be a power of two of at least 2");
   end
   if (N_GM < 2 || (1 << GIW) != N_GM) begin : g_bad_gm
      $error("N_GM must be a power of two of at least 2");
   end
   if (BEAT_W < 1) begin : g_bad_w
      $error("BEAT_W must be positive");
   end

   logic              fire;
   logic [KEY_W-1:0]  key;
   logic [GIW-1:0]    gsel_hi, gsel_lo;
   logic [KEY_W-1:0]  gmask;
   logic [N_WIDE-1:0] hits;
   logic              any_hit;
   logic [WIW-1:0]    win;

   wkt_key_asm #(.BEAT_W(BEAT_W), .N_BEATS(N_BEATS), .GIW(GIW)) u_key (
      .clk(clk), .rst_n(rst_n),
      .beat_vld(cmd_vld), .beat_first(cmd_first),
      .beat_data(cmd_data), .beat_gidx(cmd_gidx),
      .fire(fire), .key(key), .gidx_hi(gsel_hi), .gidx_lo(gsel_lo)
   );

   wkt_gmask_bank #(.HALF_W(HALF_W), .N_GM(N_GM)) u_gm (
      .clk(clk), .rst_n(rst_n),
      .wr_en(gm_ld_en), .wr_idx(gm_ld_idx), .wr_val(gm_ld_val),
      .sel_hi(gsel_hi), .sel_lo(gsel_lo), .gmask(gmask)
   );

   wkt_match_array #(.BEAT_W(BEAT_W), .N_BEATS(N_BEATS), .N_WIDE(N_WIDE)) u_arr (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data), .wr_lmask(ld_lmask),
      .key(key), .gmask(gmask), .hits(hits)
   );

   wkt_prio_enc #(.N(N_WIDE), .STYLE(PRIO_STYLE)) u_pri (
      .req(hits), .any(any_hit), .idx(win)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld <= 1'b0;
         res_hit <= 1'b0;
         res_idx <= '0;
      end else begin
         res_vld <= fire;
         if (fire) begin
            res_hit <= any_hit;
            res_idx <= any_hit ? (AW'(win) << OFS_W) : '0;
         end
      end
   end

endmodule

// File: rtl/wkt_search_chk.sv
module wkt_search_chk #(
   parameter int AW    = 6,
   parameter int OFS_W = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_vld,
   input logic          res_vld,
   input logic          res_hit,
   input logic [AW-1:0] res_idx
);
   logic [2:0] gap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       gap_q <= 3'd7;
      else if (res_vld) gap_q <= 3'd1;
      else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
   end

   a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |=> !res_vld);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !res_vld |-> ($stable(res_hit) && $stable(res_idx)));

   a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(cmd_vld));

   a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && !res_hit) |-> (res_idx == '0));

   a_r5_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> (res_idx[OFS_W-1:0] == '0));

   a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (gap_q >= 3'd4));

endmodule

bind wkt_search wkt_search_chk #(.AW(AW), .OFS_W(OFS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld),
   .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx)
);

// File: tb/wkt_search_tb.sv
module wkt_search_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmd_vld = 1'b0, cmd_first = 1'b0;
   logic [67:0]  cmd_data = '0;
   logic [2:0]   cmd_gidx = '0;
   logic         ld_en = 1'b0;
   logic [5:0]   ld_addr = '0;
   logic [67:0]  ld_data = '0, ld_lmask = '0;
   logic         gm_ld_en = 1'b0;
   logic [2:0]   gm_ld_idx = '0;
   logic [135:0] gm_ld_val = '0;
   logic         res_vld, res_hit;
   logic [5:0]   res_idx;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;   // 125 MHz

   wkt_search u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_vld(cmd_vld), .cmd_first(cmd_first), .cmd_data(cmd_data), .cmd_gidx(cmd_gidx),
      .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .ld_lmask(ld_lmask),
      .gm_ld_en(gm_ld_en), .gm_ld_idx(gm_ld_idx), .gm_ld_val(gm_ld_val),
      .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [271:0] pat(input int w);
      logic [271:0] r;
      for (int b = 0; b < 4; b++)
         r[271-68*b -: 68] = {32'hC0DE0000 | 32'(w), 4'(b), 32'h5A5A0000 ^ 32'(w*7+b)};
      return r;
   endfunction

   task automatic load_loc(input logic [5:0] a, input logic [67:0] d, input logic [67:0] m);
      @(negedge clk);
      ld_en = 1'b1; ld_addr = a; ld_data = d; ld_lmask = m;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic load_entry(input int w, input logic [271:0] k);
      for (int b = 0; b < 4; b++) load_loc(6'(4*w+b), k[271-68*b -: 68], '0);
   endtask

   task automatic load_gm(input logic [2:0] i, input logic [135:0] v);
      @(negedge clk);
      gm_ld_en = 1'b1; gm_ld_idx = i; gm_ld_val = v;
      @(negedge clk);
      gm_ld_en = 1'b0;
   endtask

   // Four beats, optional load on the fourth beat, then sample the result.
   task automatic search(input logic [271:0] k, input logic [2:0] ga, gb, gc, gd,
                         input bit cw, input logic [5:0] ca, input logic [67:0] cd,
                         output bit vld, output bit hit, output logic [5:0] idx);
      for (int b = 0; b < 4; b++) begin
         @(negedge clk);
         cmd_vld = 1'b1; cmd_first = (b == 0);
         cmd_data = k[271-68*b -: 68];
         case (b)
            0: cmd_gidx = ga;
            1: cmd_gidx = gb;
            2: cmd_gidx = gc;
            default: cmd_gidx = gd;
         endcase
         if (b == 3 && cw) begin
            ld_en = 1'b1; ld_addr = ca; ld_data = cd; ld_lmask = '0;
         end
      end
      @(negedge clk);
      cmd_vld = 1'b0; cmd_first = 1'b0; ld_en = 1'b0;
      vld = res_vld; hit = res_hit; idx = res_idx;
   endtask

   task automatic expect_search(input string req, input logic [271:0] k,
                                input logic [2:0] ga, gc, input bit eh, input int ei);
      bit v, h; logic [5:0] ix;
      search(k, ga, 3'd0, gc, 3'd0, 1'b0, '0, '0, v, h, ix);
      chk(req, "res_vld", v, 1);
      chk(req, "res_hit", h, eh);
      chk(req, "res_idx", ix, ei);
   endtask

   task automatic t_reset;
      chk("R10", "res_vld after reset", res_vld, 0);
      chk("R10", "res_hit after reset", res_hit, 0);
      chk("R10", "res_idx after reset", res_idx, 0);
      expect_search("R10", '0, 3'd0, 3'd0, 1'b1, 0);
   endtask

   task automatic t_exact_r1;
      logic [271:0] k;
      expect_search("R5", pat(5), 3'd0, 3'd0, 1'b1, 20);
      expect_search("R5", pat(15), 3'd0, 3'd0, 1'b1, 60);
      k = pat(5);
      k[271:204] = pat(5)[67:0];
      k[67:0]    = pat(5)[271:204];
      expect_search("R1", k, 3'd0, 3'd0, 1'b0, 0);
   endtask

   task automatic t_lmask_r2;
      logic [271:0] k;
      load_loc(6'd13, pat(3)[203:136], 68'hF);
      k = pat(3); k[136] = ~k[136];
      expect_search("R2", k, 3'd0, 3'd0, 1'b1, 12);
      k = pat(3); k[140] = ~k[140];
      expect_search("R2", k, 3'd0, 3'd0, 1'b0, 0);
   endtask

   task automatic t_gmask_r3;
      logic [271:0] k;
      bit v, h; logic [5:0] ix;
      load_gm(3'd2, {{135{1'b1}}, 1'b0});
      k = pat(7); k[0] = ~k[0];
      expect_search("R3", k, 3'd0, 3'd2, 1'b1, 28);
      expect_search("R3", k, 3'd2, 3'd0, 1'b0, 0);
      search(k, 3'd0, 3'd2, 3'd0, 3'd2, 1'b0, '0, '0, v, h, ix);
      chk("R3", "hit with indexes on beats B/D", h, 0);
      k = pat(7); k[136] = ~k[136];
      expect_search("R2", k, 3'd2, 3'd0, 1'b1, 28);
      expect_search("R3", k, 3'd0, 3'd2, 1'b0, 0);
   endtask

   task automatic t_prio_r4;
      load_gm(3'd3, '0);
      expect_search("R4", pat(9), 3'd3, 3'd3, 1'b1, 0);
      load_entry(11, pat(13));
      expect_search("R4", pat(13), 3'd0, 3'd0, 1'b1, 44);
      load_entry(11, pat(11));
      expect_search("R4", pat(13), 3'd0, 3'd0, 1'b1, 52);
   endtask

   task automatic t_miss_hold;
      expect_search("R5", pat(15), 3'd0, 3'd0, 1'b1, 60);
      for (int i = 0; i < 3; i++) @(negedge clk);
      chk("R7", "res_vld idle", res_vld, 0);
      chk("R7", "res_hit held", res_hit, 1);
      chk("R7", "res_idx held", res_idx, 60);
      expect_search("R6", '1, 3'd0, 3'd0, 1'b0, 0);
   endtask

   task automatic t_b2b_r8;
      logic [271:0] k;
      for (int i = 0; i <= 8; i++) begin
         @(negedge clk);
         if (i == 4) begin
            chk("R8", "first pulse", res_vld, 1);
            chk("R8", "first idx", res_idx, 4);
         end
         if (i == 5) chk("R7", "pulse one cycle", res_vld, 0);
         if (i == 7) chk("R7", "idx held while next key forms", res_idx, 4);
         if (i == 8) begin
            chk("R8", "second pulse", res_vld, 1);
            chk("R8", "second idx", res_idx, 8);
         end
         if (i < 8) begin
            k = (i < 4) ? pat(1) : pat(2);
            cmd_vld = 1'b1; cmd_first = (i % 4 == 0);
            cmd_data = k[271-68*(i%4) -: 68]; cmd_gidx = '0;
         end else begin
            cmd_vld = 1'b0; cmd_first = 1'b0;
         end
      end
   endtask

   task automatic t_restart_r8;
      bit seen;
      logic [271:0] k;
      seen = 1'b0;
      // stray beats with no key in progress
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (res_vld) seen = 1'b1;
         cmd_vld = 1'b1; cmd_first = 1'b0; cmd_data = pat(6)[67:0];
      end
      @(negedge clk); if (res_vld) seen = 1'b1;
      cmd_vld = 1'b0;
      @(negedge clk); if (res_vld) seen = 1'b1;
      chk("R8", "stray beats ignored", seen, 0);
      // partial key abandoned by a new first beat
      k = pat(6);
      @(negedge clk); cmd_vld = 1'b1; cmd_first = 1'b1; cmd_data = '1;
      @(negedge clk); cmd_first = 1'b0; cmd_data = '1;
      for (int b = 0; b < 4; b++) begin
         @(negedge clk);
         if (res_vld) seen = 1'b1;
         cmd_first = (b == 0); cmd_data = k[271-68*b -: 68];
      end
      @(negedge clk);
      cmd_vld = 1'b0;
      chk("R8", "no result from abandoned key", seen, 0);
      chk("R8", "restart res_vld", res_vld, 1);
      chk("R8", "restart res_idx", res_idx, 24);
   endtask

   task automatic t_collide_r9;
      bit v, h; logic [5:0] ix;
      search(pat(8), 3'd0, 3'd0, 3'd0, 3'd0, 1'b1, 6'd32, 68'h0, v, h, ix);
      chk("R9", "hit uses old contents", h, 1);
      chk("R9", "idx uses old contents", ix, 32);
      search(pat(8), 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, '0, '0, v, h, ix);
      chk("R9", "write visible to next search", h, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int w = 0; w < 16; w++) load_entry(w, pat(w));
      t_exact_r1();
      t_lmask_r2();
      t_gmask_r3();
      t_prio_r4();
      t_miss_hold();
      t_b2b_r8();
      t_restart_r8();
      t_collide_r9();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule